// File: doc/BRIEF.md
# First-Hit Channel Address Encoder

This block watches a bank of 64 per-channel event lines and reports which channel fired first after it was armed. Each channel offers two event sources, a threshold-crossing pulse and a peak-found pulse. A mode input picks which source is used, and a mask excludes chosen channels. On the first clock edge that sees a selected, unmasked event, the block raises a fast flag and drives the winning channel's 6-bit address. Flag and address then hold while further events are ignored.

The winner is found in two levels. An OR over each group of 8 channels comes first, then the lowest active group is picked, then the lowest active channel inside that group. When several channels fire in the same clock cycle, the lowest-numbered one wins. The captured result clears in one of two ways. A timed self-clear drops the flag a programmable number of cycles after capture; at 125 MHz a count of 5 gives a 40 ns hold. A synchronous acquisition reset clears the flag at once. With the self-clear off, the flag holds until that reset.

Top module: `first_hit_encoder`

## Requirements
- R1: After rst_n is low, hit_flag is 0. Whenever hit_flag is 0, hit_addr is 0.
- R2: When the block is enabled and hit_flag is 0, a selected, unmasked event at a clock edge sets hit_flag from that edge. hit_addr then shows the channel index in binary (bit 0 is the LSB).
- R3: When several eligible channels assert at the same edge, hit_addr is the lowest channel index among them. This holds both within a group of 8 and across groups.
- R4: With use_peak=0 only thr_evt can trigger a capture. With use_peak=1 only pk_evt can. Events on the unselected source have no effect on hit_flag.
- R5: While enable is 0, no capture takes place and hit_flag stays 0.
- R6: A channel whose mask bit is 1 never triggers a capture and never wins arbitration.
- R7: While hit_flag is 1, channel events are ignored and hit_addr stays stable.
- R8: With self_rst_en=1 and self_rst_cycles=N, hit_flag stays high for exactly max(N,1) cycles and then falls. Events present at the clearing edge are not captured; a capture can happen at the next edge.
- R9: With self_rst_en=0, hit_flag stays high until acq_rst or rst_n clears it.
- R10: acq_rst=1 at an edge clears hit_flag and hit_addr at that edge. It has priority over capture and over self-clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_rst | input | 1 | Synchronous acquisition reset, clears the captured result |
| enable | input | 1 | Arms first-hit capture |
| use_peak | input | 1 | 0: threshold events trigger, 1: peak events trigger |
| self_rst_en | input | 1 | Enables the timed self-clear |
| self_rst_cycles | input | 8 | Flag hold length in cycles for the self-clear |
| mask | input | 64 | Per-channel exclusion, 1 excludes the channel |
| thr_evt | input | 64 | Threshold-crossing event per channel |
| pk_evt | input | 64 | Peak-found event per channel |
| hit_flag | output | 1 | First hit captured |
| hit_addr | output | 6 | Address of the first-hit channel |

## Verification
The bound checker watches several properties on every cycle. It checks that the address is zero whenever the flag is low and that the address stays frozen while the flag stays up. It checks that any capture was enabled, came from an unmasked channel, and came from the selected source. It also checks that acquisition reset always clears the flag, and that the flag never drops on its own when self-clear is off. Some behaviour needs the bench's scenarios instead: lowest-index arbitration across ties, the exact hold length for each self-clear count, and re-arming at the edge after a self-clear. For these the bench runs directed cases and a seeded random stream against a cycle model.

// File: rtl/first_hit_encoder.sv
module first_hit_encoder #(
  parameter int NCH   = 64,
  parameter int GRP   = 8,
  parameter int CNT_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     acq_rst,
  input  logic                     enable,
  input  logic                     use_peak,
  input  logic                     self_rst_en,
  input  logic [CNT_W-1:0]         self_rst_cycles,
  input  logic [NCH-1:0]           mask,
  input  logic [NCH-1:0]           thr_evt,
  input  logic [NCH-1:0]           pk_evt,
  output logic                     hit_flag,
  output logic [$clog2(NCH)-1:0]   hit_addr
);
  localparam int NGRP = NCH / GRP;
  localparam int AW   = $clog2(NCH);
  localparam int GW   = $clog2(GRP);
  localparam int SW   = $clog2(NGRP);

  logic [NCH-1:0]  live;
  logic [NGRP-1:0] grp_any;
  logic [SW-1:0]   grp_idx;
  logic [GRP-1:0]  grp_bits;
  logic [GW-1:0]   ch_idx;
  logic [CNT_W-1:0] cnt;
  logic            expire;

  assign live = (use_peak ? pk_evt : thr_evt) & ~mask;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp_or
    assign grp_any[g] = |live[g*GRP +: GRP];
  end

  always_comb begin
    grp_idx = '0;
    for (int g = NGRP-1; g >= 0; g--)
      if (grp_any[g]) grp_idx = SW'(g);
  end

  assign grp_bits = live[grp_idx*GRP +: GRP];

  always_comb begin
    ch_idx = '0;
    for (int c = GRP-1; c >= 0; c--)
      if (grp_bits[c]) ch_idx = GW'(c);
  end

  assign expire = self_rst_en &&
                  ({1'b0, cnt} + (CNT_W+1)'(1) >= {1'b0, self_rst_cycles});

  always_ff @(posedge clk) begin
    if (!rst_n || acq_rst) begin
      hit_flag <= 1'b0;
      hit_addr <= '0;
      cnt      <= '0;
    end else if (hit_flag) begin
      if (expire) begin
        hit_flag <= 1'b0;
        hit_addr <= '0;
        cnt      <= '0;
      end else if (cnt != {CNT_W{1'b1}}) begin
        cnt <= cnt + 1'b1;
      end
    end else if (enable && |grp_any) begin
      hit_flag <= 1'b1;
      hit_addr <= AW'({grp_idx, ch_idx});
      cnt      <= '0;
    end
  end
endmodule

// File: rtl/first_hit_encoder_chk.sv
module first_hit_encoder_chk #(
  parameter int NCH   = 64,
  parameter int CNT_W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   acq_rst,
  input logic                   enable,
  input logic                   use_peak,
  input logic                   self_rst_en,
  input logic [NCH-1:0]         mask,
  input logic [NCH-1:0]         thr_evt,
  input logic [NCH-1:0]         pk_evt,
  input logic                   hit_flag,
  input logic [$clog2(NCH)-1:0] hit_addr
);
  logic [NCH-1:0] mask_d, src_d;
  always_ff @(posedge clk) begin
    mask_d <= mask;
    src_d  <= use_peak ? pk_evt : thr_evt;
  end

  assert_addr_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_flag |-> hit_addr == '0);

  assert_capture_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hit_flag) |-> $past(enable));

  assert_capture_unmasked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hit_flag) |-> !mask_d[hit_addr]);

  assert_capture_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hit_flag) |-> src_d[hit_addr]);

  assert_addr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_flag && $past(hit_flag)) |-> $stable(hit_addr));

  assert_acq_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    acq_rst |=> !hit_flag);

  assert_no_self_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_flag && !self_rst_en && !acq_rst) |=> hit_flag);
endmodule

bind first_hit_encoder first_hit_encoder_chk #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acq_rst(acq_rst), .enable(enable),
  .use_peak(use_peak), .self_rst_en(self_rst_en), .mask(mask),
  .thr_evt(thr_evt), .pk_evt(pk_evt), .hit_flag(hit_flag), .hit_addr(hit_addr)
);

// File: tb/first_hit_encoder_tb.sv
module first_hit_encoder_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        acq_rst = 0;
  logic        enable = 0;
  logic        use_peak = 0;
  logic        self_rst_en = 0;
  logic [7:0]  self_rst_cycles = 0;
  logic [63:0] mask = 0, thr_evt = 0, pk_evt = 0;
  logic        hit_flag;
  logic [5:0]  hit_addr;

  int vectors = 0, errors = 0;
  bit m_flag = 0;
  logic [5:0] m_addr = 0;
  int m_cnt = 0;

  always #4 clk = ~clk;

  first_hit_encoder u_dut (
    .clk(clk), .rst_n(rst_n), .acq_rst(acq_rst), .enable(enable),
    .use_peak(use_peak), .self_rst_en(self_rst_en),
    .self_rst_cycles(self_rst_cycles), .mask(mask), .thr_evt(thr_evt),
    .pk_evt(pk_evt), .hit_flag(hit_flag), .hit_addr(hit_addr));

  function automatic int first_index(input logic [63:0] v);
    for (int i = 0; i < 64; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic int hold_len(input logic [7:0] n);
    return (n == 0) ? 1 : int'(n);
  endfunction

  task automatic model_edge();
    int w;
    w = first_index((use_peak ? pk_evt : thr_evt) & ~mask);
    if (!rst_n || acq_rst) begin
      m_flag = 0; m_addr = 0; m_cnt = 0;
    end else if (m_flag) begin
      if (self_rst_en && m_cnt + 1 >= int'(self_rst_cycles)) begin
        m_flag = 0; m_addr = 0; m_cnt = 0;
      end else if (m_cnt < 255) m_cnt++;
    end else if (enable && w >= 0) begin
      m_flag = 1; m_addr = 6'(w); m_cnt = 0;
    end
  endtask

  task automatic cyc(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    vectors++;
    if (hit_flag !== m_flag || hit_addr !== m_addr) begin
      errors++;
      $display("FAIL %s: flag/addr actual %0b/%0d expected %0b/%0d at %0t",
               tag, hit_flag, hit_addr, m_flag, m_addr, $time);
    end
  endtask

  task automatic idle();
    thr_evt = 0; pk_evt = 0; acq_rst = 0;
  endtask

  task automatic clear();
    idle(); acq_rst = 1; cyc("R10"); acq_rst = 0;
  endtask

  task automatic expect_val(input string tag, input bit f, input int a);
    vectors++;
    if (hit_flag !== f || int'(hit_addr) != a) begin
      errors++;
      $display("FAIL %s: flag/addr actual %0b/%0d expected %0b/%0d",
               tag, hit_flag, hit_addr, f, a);
    end
  endtask

  function automatic logic [63:0] sparse(input int shift);
    logic [63:0] v = 0;
    for (int i = 0; i < 64; i++) if (($urandom() >> shift) % 40 == 0) v[i] = 1;
    return v;
  endfunction

  initial begin
    void'($urandom(32'd20240517));
    @(negedge clk);
    cyc("R1"); cyc("R1");
    rst_n = 1;
    expect_val("R1", 0, 0);
    enable = 1;

    thr_evt[37] = 1; cyc("R2"); idle();
    expect_val("R2", 1, 37);
    clear();

    thr_evt[10] = 1; thr_evt[9] = 1; thr_evt[63] = 1; cyc("R3"); idle();
    expect_val("R3", 1, 9);
    clear();
    thr_evt[40] = 1; thr_evt[17] = 1; cyc("R3"); idle();
    expect_val("R3", 1, 17);
    clear();

    use_peak = 1; thr_evt[5] = 1; cyc("R4"); idle();
    expect_val("R4", 0, 0);
    pk_evt[50] = 1; thr_evt[2] = 1; cyc("R4"); idle();
    expect_val("R4", 1, 50);
    clear(); use_peak = 0;

    enable = 0; thr_evt[3] = 1; cyc("R5"); cyc("R5"); idle();
    expect_val("R5", 0, 0);
    enable = 1;

    mask[4] = 1; thr_evt[4] = 1; cyc("R6");
    expect_val("R6", 0, 0);
    thr_evt[12] = 1; cyc("R6"); idle(); mask = 0;
    expect_val("R6", 1, 12);

    thr_evt[0] = 1; cyc("R7"); cyc("R7"); idle();
    expect_val("R7", 1, 12);
    clear();

    self_rst_en = 1; self_rst_cycles = 5;
    thr_evt[22] = 1; cyc("R8"); idle();
    for (int k = 1; k < 5; k++) begin
      cyc("R8"); expect_val("R8", 1, 22);
    end
    thr_evt[30] = 1; cyc("R8");
    expect_val("R8", 0, 0);
    cyc("R8"); idle();
    expect_val("R8", 1, 30);
    clear();
    self_rst_cycles = 0; thr_evt[8] = 1; cyc("R8"); idle();
    expect_val("R8", 1, 8);
    cyc("R8");
    expect_val("R8", 0, 0);

    self_rst_en = 0; thr_evt[44] = 1; cyc("R9"); idle();
    for (int k = 0; k < 50; k++) cyc("R9");
    expect_val("R9", 1, 44);

    self_rst_en = 1; self_rst_cycles = 1; acq_rst = 1; thr_evt[1] = 1; cyc("R10");
    expect_val("R10", 0, 0);
    acq_rst = 0; cyc("R10"); idle();
    expect_val("R10", 1, 1);
    clear();

    for (int n = 0; n < 6000; n++) begin
      thr_evt = sparse(0);
      pk_evt  = sparse(3);
      acq_rst = ($urandom() % 60) == 0;
      if (($urandom() % 100) == 0) enable = ~enable;
      if (!m_flag && ($urandom() % 50) == 0) begin
        use_peak = $urandom();
        self_rst_en = ($urandom() % 4) != 0;
        self_rst_cycles = 8'($urandom() % 8);
        mask = sparse(5);
      end
      cyc("R2 random");
    end
    idle();
    if (hold_len(self_rst_cycles) < 1) errors++;

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule